// File: doc/BRIEF.md
# Accumulator Machine Micro-operation Sequencer

This block is the hardwired control unit of a small single-accumulator machine. It has a behavioural datapath and memory model attached to it so that it can be exercised. An instruction word is taken in while the sequencer waits in its fetch state. Each word holds a two-bit opcode and a memory address. The sequencer then issues one register-transfer micro-operation per clock beat to carry out that instruction. An add-from-memory instruction moves the address into the memory address register and strobes a read. It then captures the memory word in the memory data register and adds it into the accumulator. A store instruction moves the address into the address register and arms a write. It then copies the accumulator into the data register and commits that register to memory.

Every execute cycle ends with a check for a pending interrupt. A request latched while interrupts are enabled starts a hidden interrupt sequence. That sequence saves the program counter as the return point and jumps to a fixed vector. The return point goes either to memory cell 0 or, when the stack-mode input is high, to a descending stack. The sequence then turns interrupts off. A dedicated opcode turns them back on.

Top module: `acc_seq_top`

## Requirements
- R1: After reset the accumulator, program counter and interrupt enable are 0, the stack pointer is all ones, the sequencer is in its fetch state, and memory word i holds (5*i+3) truncated to the data width.
- R2: The instruction word is {opcode[1:0], address}. Opcode 2'b01 (add) adds the memory word at the address into the accumulator and returns to fetch after 5 beats, fetch included. The accumulator changes only in the beat that carries the add command.
- R3: Opcode 2'b10 (store) writes the accumulator to the memory word at the address in 5 beats, and leaves the accumulator unchanged.
- R4: The memory read strobe and the memory write strobe are never high in the same beat.
- R5: An interrupt cycle starts only at the end of an execute cycle and only when a request is pending. A one-beat request raised in the middle of an execute cycle is held and served when that cycle ends.
- R6: With stack mode low, the interrupt cycle takes 6 beats and writes the incremented program counter of the interrupted instruction to memory word 0.
- R7: The interrupt cycle loads the program counter with the parameter VEC_ADDR (12 by default).
- R8: The interrupt cycle clears the interrupt enable. A request raised while the enable is clear is dropped and does not cause a later interrupt cycle.
- R9: With stack mode high, the interrupt cycle takes 7 beats. It decrements the stack pointer first and then stores the return point at the new stack pointer address.
- R10: Opcode 2'b11 sets the interrupt enable. Opcode 2'b00 changes nothing except the program counter. Both take 2 beats, and every fetch adds 1 to the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word offered; taken when fetch_rdy is high |
| instr_word | input | 2+AW | Opcode in the top two bits, memory address below |
| irq_req | input | 1 | Interrupt request from the system bus |
| stack_mode | input | 1 | 1 selects stack saving of the return point, 0 selects memory word 0 |
| fetch_rdy | output | 1 | Sequencer is in its fetch state |
| mem_rd | output | 1 | Memory read strobe beat |
| mem_wr | output | 1 | Memory write strobe beat |
| alu_add | output | 1 | ALU add command beat |
| in_irq | output | 1 | Sequencer is in the interrupt cycle |
| acc | output | DW | Accumulator |
| pc | output | AW | Program counter |
| sp | output | AW | Stack pointer |
| ie | output | 1 | Interrupt enable flip-flop |

## Verification
The bench uses the defaults: a 4-bit address, 16 memory words of 8 bits, and vector 12. With these values the return-point sums stay below 256, so every accumulator value can be predicted exactly. The first stack save lands on word 14, which the add instruction can reach. Saved return points are read back at the ports by adding the save cell into the accumulator, and store results are read back the same way. Beat counts for each path, including the interrupt cycle, are measured from the issue beat until fetch_rdy is high again.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

    typedef enum logic [1:0] {
        OP_NOP   = 2'b00,
        OP_ADD   = 2'b01,
        OP_STORE = 2'b10,
        OP_EI    = 2'b11
    } opcode_e;

    typedef enum logic [4:0] {
        S_FETCH,
        S_ADD_MAR, S_ADD_RD, S_ADD_MDR, S_ADD_ACC,
        S_ST_MAR, S_ST_WR, S_ST_MDR, S_ST_MEM,
        S_SIMPLE,
        S_INT_MAR0, S_INT_SPDEC, S_INT_SPMAR,
        S_INT_WR, S_INT_MDR, S_INT_MEM, S_INT_VEC, S_INT_CLR
    } seq_state_e;

    typedef struct packed {
        logic ir_ld;
        logic pc_inc;
        logic mar_from_ir;
        logic mar_zero;
        logic mar_from_sp;
        logic sp_dec;
        logic mem_rd;
        logic mem_wr_arm;
        logic mdr_from_mem;
        logic mdr_from_acc;
        logic mdr_from_pc;
        logic mem_commit;
        logic alu_add;
        logic pc_vec;
        logic ie_clr;
        logic ie_set;
        logic int_ack;
    } uop_t;

    function automatic int mem_seed(int idx);
        return idx * 5 + 3;
    endfunction

endpackage

// File: rtl/acc_seq_irq.sv
module acc_seq_irq (
    input  logic clk,
    input  logic rst,
    input  logic irq_req,
    input  logic ie_set,
    input  logic ie_clr,
    input  logic int_ack,
    output logic ie,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ie   <= 1'b0;
            pend <= 1'b0;
        end else begin
            if (ie_clr)      ie <= 1'b0;
            else if (ie_set) ie <= 1'b1;

            if (ie_clr || int_ack)   pend <= 1'b0;
            else if (ie && irq_req)  pend <= 1'b1;
        end
    end

    // R8: clearing the enable also drops any held request
    assert_ie_clear_R8: assert property (@(posedge clk) disable iff (rst)
        ie_clr |=> (!ie && !pend));

    // R8: no request is held while the enable is off
    assert_no_pend_when_off_R8: assert property (@(posedge clk) disable iff (rst)
        (!ie && !ie_set) |=> !pend);

endmodule

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
    import acc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       instr_valid,
    input  logic [1:0] instr_op,
    input  logic       pend,
    input  logic       stack_mode,
    output uop_t       uop,
    output logic       fetch_rdy,
    output logic       in_irq
);
    seq_state_e state, state_n;

    always_ff @(posedge clk) begin
        if (rst) state <= S_FETCH;
        else     state <= state_n;
    end

    always_comb begin
        uop     = '0;
        state_n = state;
        case (state)
            S_FETCH: if (instr_valid) begin
                uop.ir_ld  = 1'b1;
                uop.pc_inc = 1'b1;
                case (opcode_e'(instr_op))
                    OP_ADD:   state_n = S_ADD_MAR;
                    OP_STORE: state_n = S_ST_MAR;
                    default:  state_n = S_SIMPLE;
                endcase
            end
            S_ADD_MAR:   begin uop.mar_from_ir = 1'b1;  state_n = S_ADD_RD;  end
            S_ADD_RD:    begin uop.mem_rd = 1'b1;       state_n = S_ADD_MDR; end
            S_ADD_MDR:   begin uop.mdr_from_mem = 1'b1; state_n = S_ADD_ACC; end
            S_ADD_ACC:   uop.alu_add = 1'b1;
            S_ST_MAR:    begin uop.mar_from_ir = 1'b1;  state_n = S_ST_WR;   end
            S_ST_WR:     begin uop.mem_wr_arm = 1'b1;   state_n = S_ST_MDR;  end
            S_ST_MDR:    begin uop.mdr_from_acc = 1'b1; state_n = S_ST_MEM;  end
            S_ST_MEM:    uop.mem_commit = 1'b1;
            S_SIMPLE:    ;
            S_INT_MAR0:  begin uop.mar_zero = 1'b1;     state_n = S_INT_WR;  end
            S_INT_SPDEC: begin uop.sp_dec = 1'b1;       state_n = S_INT_SPMAR; end
            S_INT_SPMAR: begin uop.mar_from_sp = 1'b1;  state_n = S_INT_WR;  end
            S_INT_WR:    begin uop.mem_wr_arm = 1'b1;   state_n = S_INT_MDR; end
            S_INT_MDR:   begin uop.mdr_from_pc = 1'b1;  state_n = S_INT_MEM; end
            S_INT_MEM:   begin uop.mem_commit = 1'b1;   state_n = S_INT_VEC; end
            S_INT_VEC:   begin uop.pc_vec = 1'b1;       state_n = S_INT_CLR; end
            S_INT_CLR:   begin uop.ie_clr = 1'b1;       state_n = S_FETCH;   end
            default:     state_n = S_FETCH;
        endcase

        // end-of-execute interrupt check
        if (state == S_ADD_ACC || state == S_ST_MEM || state == S_SIMPLE) begin
            if (state == S_SIMPLE && instr_op_q == OP_EI) uop.ie_set = 1'b1;
            if (pend) begin
                uop.int_ack = 1'b1;
                state_n = stack_mode ? S_INT_SPDEC : S_INT_MAR0;
            end else begin
                state_n = S_FETCH;
            end
        end
    end

    opcode_e instr_op_q;
    always_ff @(posedge clk) begin
        if (rst)            instr_op_q <= OP_NOP;
        else if (uop.ir_ld) instr_op_q <= opcode_e'(instr_op);
    end

    assign fetch_rdy = (state == S_FETCH);
    assign in_irq    = (state >= S_INT_MAR0);

    // R4: read and write strobes never share a beat
    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(uop.mem_rd && uop.mem_wr_arm));

    // R5: once the interrupt cycle is entered it runs before the next fetch
    assert_ack_enters_irq_R5: assert property (@(posedge clk) disable iff (rst)
        uop.int_ack |=> (in_irq && !fetch_rdy));

endmodule

// File: rtl/acc_seq_datapath.sv
module acc_seq_datapath
    import acc_seq_pkg::*;
#(
    parameter int AW       = 4,
    parameter int DW       = 8,
    parameter int VEC_ADDR = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  uop_t          uop,
    input  logic [AW+1:0] instr_word,
    output logic [DW-1:0] acc,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] sp
);
    localparam int DEPTH = 1 << AW;

    logic [AW-1:0] ir_addr, mar;
    logic [DW-1:0] mdr, rdata;
    logic          wr_armed;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_addr  <= '0;
            pc       <= '0;
            sp       <= '1;
            mar      <= '0;
            mdr      <= '0;
            rdata    <= '0;
            acc      <= '0;
            wr_armed <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= DW'(mem_seed(i));
        end else begin
            if (uop.ir_ld)        ir_addr <= instr_word[AW-1:0];
            if (uop.pc_vec)       pc <= AW'(VEC_ADDR);
            else if (uop.pc_inc)  pc <= pc + 1'b1;
            if (uop.sp_dec)       sp <= sp - 1'b1;
            if (uop.mar_from_ir)  mar <= ir_addr;
            else if (uop.mar_zero)    mar <= '0;
            else if (uop.mar_from_sp) mar <= sp;
            if (uop.mem_rd)       rdata <= mem[mar];
            if (uop.mdr_from_mem)      mdr <= rdata;
            else if (uop.mdr_from_acc) mdr <= acc;
            else if (uop.mdr_from_pc)  mdr <= DW'(pc);
            if (uop.alu_add)      acc <= acc + mdr;
            if (uop.mem_wr_arm)   wr_armed <= 1'b1;
            else if (uop.mem_commit) begin
                wr_armed <= 1'b0;
                if (wr_armed) mem[mar] <= mdr;
            end
        end
    end

    // R2: accumulator only moves on an add beat
    assert_acc_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !uop.alu_add |=> $stable(acc));

    // R7: vector beat lands the fixed vector in the program counter
    assert_vec_load_R7: assert property (@(posedge clk) disable iff (rst)
        uop.pc_vec |=> (pc == AW'(VEC_ADDR)));

    // R9: stack pointer steps down by one on a push beat
    assert_sp_dec_R9: assert property (@(posedge clk) disable iff (rst)
        uop.sp_dec |=> (sp == $past(sp) - 1'b1));

endmodule

// File: rtl/acc_seq_top.sv
module acc_seq_top
    import acc_seq_pkg::*;
#(
    parameter int AW       = 4,
    parameter int DW       = 8,
    parameter int VEC_ADDR = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          instr_valid,
    input  logic [AW+1:0] instr_word,
    input  logic          irq_req,
    input  logic          stack_mode,
    output logic          fetch_rdy,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          alu_add,
    output logic          in_irq,
    output logic [DW-1:0] acc,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] sp,
    output logic          ie
);
    uop_t uop;
    logic pend;

    acc_seq_ctrl u_ctrl (
        .clk(clk), .rst(rst), .instr_valid(instr_valid),
        .instr_op(instr_word[AW+1:AW]), .pend(pend), .stack_mode(stack_mode),
        .uop(uop), .fetch_rdy(fetch_rdy), .in_irq(in_irq)
    );

    acc_seq_irq u_irq (
        .clk(clk), .rst(rst), .irq_req(irq_req), .ie_set(uop.ie_set),
        .ie_clr(uop.ie_clr), .int_ack(uop.int_ack), .ie(ie), .pend(pend)
    );

    acc_seq_datapath #(.AW(AW), .DW(DW), .VEC_ADDR(VEC_ADDR)) u_dp (
        .clk(clk), .rst(rst), .uop(uop), .instr_word(instr_word),
        .acc(acc), .pc(pc), .sp(sp)
    );

    assign mem_rd  = uop.mem_rd;
    assign mem_wr  = uop.mem_wr_arm;
    assign alu_add = uop.alu_add;

    // R5: the interrupt cycle is only entered with a request held
    assert_irq_entry_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(in_irq) |-> $past(pend));

    // R8: interrupt cycle always leaves the enable clear
    assert_exit_ie_off_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(in_irq) |-> !ie);

endmodule

// File: tb/acc_seq_top_bench.sv
module acc_seq_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int VEC = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          instr_valid = 1'b0;
    logic [AW+1:0] instr_word = '0;
    logic          irq_req = 1'b0;
    logic          stack_mode = 1'b0;
    logic          fetch_rdy, mem_rd, mem_wr, alu_add, in_irq, ie;
    logic [DW-1:0] acc;
    logic [AW-1:0] pc, sp;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int exp_acc = 0;
    int exp_pc  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_seq_top #(.AW(AW), .DW(DW), .VEC_ADDR(VEC)) u_acc_seq_top (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .irq_req(irq_req), .stack_mode(stack_mode), .fetch_rdy(fetch_rdy),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .alu_add(alu_add), .in_irq(in_irq),
        .acc(acc), .pc(pc), .sp(sp), .ie(ie)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: act=%0d exp=<100000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // issue one instruction; irq_at = beat index at which a one-beat request is raised (-1 none)
    task automatic issue(input int op, input int addr, input int irq_at, output int beats);
        while (!fetch_rdy) @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = {op[1:0], addr[AW-1:0]};
        irq_req     = (irq_at == 0);
        beats = 0;
        do begin
            @(negedge clk);
            beats++;
            instr_valid = 1'b0;
            irq_req     = (beats == irq_at);
        end while (!fetch_rdy && beats < 50);
        irq_req = 1'b0;
        exp_pc  = (exp_pc + 1) % 16;
    endtask

    task automatic t_reset();
        chk("R1 acc", int'(acc), 0);
        chk("R1 pc", int'(pc), 0);
        chk("R1 ie", int'(ie), 0);
        chk("R1 sp", int'(sp), 15);
        chk("R1 fetch_rdy", int'(fetch_rdy), 1);
    endtask

    task automatic t_add();
        int b;
        issue(1, 2, -1, b);
        exp_acc += 13;
        chk("R2 add beats", b, 5);
        chk("R2 acc after add 2", int'(acc), exp_acc);
        issue(1, 7, -1, b);
        exp_acc += 38;
        chk("R2 acc after add 7", int'(acc), exp_acc);
        chk("R10 pc increments", int'(pc), exp_pc);
    endtask

    task automatic t_store();
        int b;
        issue(2, 9, -1, b);
        chk("R3 store beats", b, 5);
        chk("R3 acc unchanged", int'(acc), exp_acc);
        issue(1, 9, -1, b);
        exp_acc += exp_acc;
        chk("R3 stored value read back", int'(acc), exp_acc);
    endtask

    task automatic t_disabled();
        int b;
        issue(0, 0, 0, b);
        chk("R8 request ignored while ie=0 beats", b, 2);
        chk("R10 nop keeps acc", int'(acc), exp_acc);
        chk("R10 nop pc", int'(pc), exp_pc);
        issue(3, 0, -1, b);
        chk("R10 enable beats", b, 2);
        chk("R10 ie set", int'(ie), 1);
    endtask

    task automatic t_fixed_irq();
        int b, saved;
        issue(0, 0, 0, b);
        saved = exp_pc;
        chk("R6 nop plus fixed irq beats", b, 8);
        chk("R7 pc at vector", int'(pc), VEC);
        chk("R8 ie cleared", int'(ie), 0);
        chk("R6 sp untouched", int'(sp), 15);
        exp_pc = VEC;
        issue(1, 0, -1, b);
        exp_acc = (exp_acc + saved) % 256;
        chk("R6 return point in word 0", int'(acc), exp_acc);
    endtask

    task automatic t_stack_irq();
        int b, saved;
        issue(3, 0, -1, b);
        stack_mode = 1'b1;
        issue(0, 0, 0, b);
        saved = exp_pc;
        stack_mode = 1'b0;
        chk("R9 stack irq beats", b, 9);
        chk("R9 sp decremented", int'(sp), 14);
        chk("R7 pc at vector (stack)", int'(pc), VEC);
        exp_pc = VEC;
        issue(1, 14, -1, b);
        exp_acc = (exp_acc + saved) % 256;
        chk("R9 return point at new sp", int'(acc), exp_acc);
    endtask

    task automatic t_held_irq();
        int b, saved;
        issue(3, 0, -1, b);
        issue(1, 2, 3, b);
        saved = exp_pc;
        exp_acc = (exp_acc + 13) % 256;
        chk("R5 mid-execute request served beats", b, 11);
        chk("R5 add completed before irq", int'(acc), exp_acc);
        chk("R7 pc at vector (held)", int'(pc), VEC);
        exp_pc = VEC;
        issue(1, 0, -1, b);
        exp_acc = (exp_acc + saved) % 256;
        chk("R5 return point after held request", int'(acc), exp_acc);
        issue(0, 0, 0, b);
        chk("R8 request dropped after irq cycle", b, 2);
        issue(0, 0, -1, b);
        chk("R8 no late irq", b, 2);
    endtask

    task automatic t_strobes();
        int b;
        int rd_seen = 0;
        int wr_seen = 0;
        int both = 0;
        while (!fetch_rdy) @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = {2'b10, 4'd3};
        b = 0;
        do begin
            @(negedge clk);
            b++;
            instr_valid = 1'b0;
            rd_seen += int'(mem_rd);
            wr_seen += int'(mem_wr);
            both    += int'(mem_rd && mem_wr);
        end while (!fetch_rdy && b < 50);
        exp_pc = (exp_pc + 1) % 16;
        chk("R4 store write strobe beats", wr_seen, 1);
        chk("R4 store read strobe beats", rd_seen, 0);
        chk("R4 strobes never together", both, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_add();
        t_store();
        t_disabled();
        t_fixed_irq();
        t_stack_irq();
        t_held_irq();
        t_strobes();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule